// File: doc/BRIEF.md
# Debug Scan Chain Command Decoder

This block sits behind a test-access-port state machine and works entirely from the capture, shift and update strobes of the data-register scan, the serial input and the serial output, all in the test clock domain. Two serial frame kinds are decoded. A chain-select frame, accepted while the chain-select instruction is loaded, chooses which debug chain is active. Command frames, accepted while the debug instruction is loaded, carry an address, a write flag, a data word and a CRC. Their layout depends on the chain that was latched earlier.

Every frame carries a CRC-8. A command is carried out only when both the CRC and the bit count are correct. A failing frame is dropped and a sticky error flag is raised. An accepted command crosses into the system clock domain through a synchronized toggle. There it becomes a single-cycle access strobe toward either the processor port or the register-file port.

Read results are held in the block and appear on the serial output during the next scan. On the trace chain, a scan returns the current trace sample followed by its CRC.

Top module: `dbgc_jtag_cmd`

## Requirements
- R1: Every field is shifted in least significant bit first. A chain-select frame is a 4-bit chain id followed by an 8-bit CRC. It is accepted only under the chain-select instruction, and the id is latched at update only when the frame is good. Id encodings are: 0 boundary scan, 1 processor debug, 2 processor test, 3 trace test, 4 register scan. After reset the latched id is 0.
- R2: The CRC is CRC-8 with polynomial x^8+x^2+x+1, preset to 0xFF at capture. It is advanced once per payload bit in shift order, and the received CRC follows the payload LSB first. A mismatching frame is discarded and sets the sticky `crc_error` flag. A good chain-select frame clears the flag.
- R3: A register-scan command is 46 bits: a 5-bit address, a write bit (1 = write, 0 = read), 32 data bits, then the CRC.
- R4: A processor-debug command is 73 bits: a 32-bit address, a write bit, 32 data bits, then the CRC. A good frame raises `cpu_cs` for one system cycle, with `cpu_we`, `cpu_addr` and `cpu_wdata` taken from the frame.
- R5: A good register-scan command raises `reg_stb` for one system cycle, with `reg_we`, `reg_addr` and `reg_wdata`. This happens only for addresses below REG_COUNT (16).
- R6: For a read, the shifted data bits are ignored. The read value appears on the first 32 `tdo` bits of the next debug scan. Writes leave the held read value unchanged.
- R7: A register read at an address of REG_COUNT or above produces no strobe and no error, and returns zero.
- R8: A command or chain-select frame whose bit count differs from its layout length is rejected in the same way as a CRC mismatch.
- R9: On the trace-test chain, a debug scan shifts out 48 bits: the 40-bit trace sample LSB first, then the CRC-8 of that sample.
- R10: Each accepted command yields exactly one strobe within 10 test-clock cycles after update. `cpu_cs` and `reg_stb` are never high together.
- R11: Under the debug instruction, frames on chains 0 and 2 cause no access and never set `crc_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tck_rst | input | 1 | Synchronous active-high reset, test clock domain |
| capture_dr | input | 1 | Data-register capture state |
| shift_dr | input | 1 | Data-register shift state |
| update_dr | input | 1 | Data-register update state |
| ir_chain_sel | input | 1 | Chain-select instruction is loaded |
| ir_debug | input | 1 | Debug instruction is loaded |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| crc_error | output | 1 | Sticky frame-rejected flag |
| trace_sample | input | 40 | Current trace sample for the trace-test chain |
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| cpu_cs | output | 1 | Processor access strobe |
| cpu_we | output | 1 | Processor access is a write |
| cpu_addr | output | 32 | Processor access address |
| cpu_wdata | output | 32 | Processor write data |
| cpu_rdata | input | 32 | Processor read data |
| reg_stb | output | 1 | Register-file access strobe |
| reg_we | output | 1 | Register access is a write |
| reg_addr | output | 5 | Register address |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data |

## Verification
The in-line properties watch, on every cycle, several behaviours: the access strobes last one cycle and never overlap; only mapped addresses are strobed; the latched chain and the error flag change only at the proper update; a request crosses clock domains only after a correctly sized frame; and the held read value moves only after a read strobe. Other behaviours need the bench's scenarios. These are the exact field positions, the CRC values produced and checked, the read data returned in the following scan, zero for unmapped reads, the trace sample with its CRC, and the fact that a rejected frame leaves register contents intact.

// File: rtl/dbgc_pkg.sv
`timescale 1ns/1ps
package dbgc_pkg;
  localparam int CRC_W = 8;
  localparam int CHAIN_W = 4;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
  localparam logic [CRC_W-1:0] CRC_SEED = 8'hFF;

  localparam logic [CHAIN_W-1:0] CH_BSCAN   = 4'd0;
  localparam logic [CHAIN_W-1:0] CH_CPU_DBG = 4'd1;
  localparam logic [CHAIN_W-1:0] CH_CPU_TST = 4'd2;
  localparam logic [CHAIN_W-1:0] CH_TRACE   = 4'd3;
  localparam logic [CHAIN_W-1:0] CH_REGS    = 4'd4;

  function automatic logic [CRC_W-1:0] crc8_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/dbgc_crc8_ser.sv
`timescale 1ns/1ps
module dbgc_crc8_ser
  import dbgc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || init) crc <= CRC_SEED;
    else if (en)     crc <= crc8_step(crc, din);
  end
endmodule

// File: rtl/dbgc_tgl_sync.sv
`timescale 1ns/1ps
module dbgc_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES:0] sq;

  always_ff @(posedge clk) begin
    if (rst) sq <= '0;
    else     sq <= {sq[STAGES-1:0], tgl_in};
  end

  assign pulse = sq[STAGES] ^ sq[STAGES-1];
endmodule

// File: rtl/dbgc_sys_port.sv
`timescale 1ns/1ps
module dbgc_sys_port #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int REG_AW    = 5,
  parameter int REG_COUNT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              h_cpu,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              cpu_cs,
  output logic              cpu_we,
  output logic [ADDR_W-1:0] cpu_addr,
  output logic [DATA_W-1:0] cpu_wdata,
  output logic              reg_stb,
  output logic              reg_we,
  output logic [REG_AW-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] rd_data
);
  logic hit, rd_pend, rd_cpu, rd_hit;

  assign hit = h_addr < ADDR_W'(REG_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_cs <= 1'b0; cpu_we <= 1'b0; cpu_addr <= '0; cpu_wdata <= '0;
      reg_stb <= 1'b0; reg_we <= 1'b0; reg_addr <= '0; reg_wdata <= '0;
      rd_pend <= 1'b0; rd_cpu <= 1'b0; rd_hit <= 1'b0; rd_data <= '0;
    end else begin
      cpu_cs  <= go && h_cpu;
      reg_stb <= go && !h_cpu && hit;
      if (go && h_cpu) begin
        cpu_we <= h_we; cpu_addr <= h_addr; cpu_wdata <= h_wdata;
      end
      if (go && !h_cpu && hit) begin
        reg_we <= h_we; reg_addr <= h_addr[REG_AW-1:0]; reg_wdata <= h_wdata;
      end
      rd_pend <= go && !h_we;
      if (go) begin
        rd_cpu <= h_cpu;
        rd_hit <= hit;
      end
      if (rd_pend) rd_data <= rd_cpu ? cpu_rdata : (rd_hit ? reg_rdata : '0);
    end
  end

  // R10
  cs_single_chk: assert property (@(posedge clk) disable iff (rst) cpu_cs |=> !cpu_cs);
  // R10
  rs_single_chk: assert property (@(posedge clk) disable iff (rst) reg_stb |=> !reg_stb);
  // R10
  stb_excl_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({cpu_cs, reg_stb}));
  // R5
  reg_map_chk: assert property (@(posedge clk) disable iff (rst) reg_stb |-> (reg_addr < REG_AW'(REG_COUNT)));
  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst) !$stable(rd_data) |-> $past(rd_pend));
endmodule

// File: rtl/dbgc_jtag_cmd.sv
`timescale 1ns/1ps
module dbgc_jtag_cmd
  import dbgc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int REG_AW      = 5,
  parameter int REG_COUNT   = 16,
  parameter int TRACE_W     = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic               tck,
  input  logic               tck_rst,
  input  logic               capture_dr,
  input  logic               shift_dr,
  input  logic               update_dr,
  input  logic               ir_chain_sel,
  input  logic               ir_debug,
  input  logic               tdi,
  output logic               tdo,
  output logic               crc_error,
  input  logic [TRACE_W-1:0] trace_sample,
  input  logic               sys_clk,
  input  logic               sys_rst,
  output logic               cpu_cs,
  output logic               cpu_we,
  output logic [ADDR_W-1:0]  cpu_addr,
  output logic [DATA_W-1:0]  cpu_wdata,
  input  logic [DATA_W-1:0]  cpu_rdata,
  output logic               reg_stb,
  output logic               reg_we,
  output logic [REG_AW-1:0]  reg_addr,
  output logic [DATA_W-1:0]  reg_wdata,
  input  logic [DATA_W-1:0]  reg_rdata
);
  localparam int FRM_SEL   = CHAIN_W + CRC_W;
  localparam int FRM_REG   = REG_AW + 1 + DATA_W + CRC_W;
  localparam int FRM_CPU   = ADDR_W + 1 + DATA_W + CRC_W;
  localparam int FRM_TRC   = TRACE_W + CRC_W;
  localparam int SR_W      = (FRM_CPU > FRM_TRC) ? FRM_CPU : FRM_TRC;
  localparam int CNT_W     = $clog2(SR_W + 1) + 1;
  localparam int OFF_CRC   = SR_W - CRC_W;
  localparam int OFF_CHAIN = OFF_CRC - CHAIN_W;
  localparam int OFF_DATA  = OFF_CRC - DATA_W;
  localparam int OFF_WE    = OFF_DATA - 1;
  localparam int OFF_CADDR = OFF_WE - ADDR_W;
  localparam int OFF_RADDR = OFF_WE - REG_AW;

  logic [SR_W-1:0]    sr;
  logic [CNT_W-1:0]   bit_cnt, payload_len, frame_len;
  logic [CRC_W-1:0]   crc_calc, trace_crc;
  logic [CHAIN_W-1:0] chain_q;
  logic               is_cpu, is_reg, is_trc, frame_ok, sel_upd, cmd_upd;
  logic               req_tgl, h_cpu, h_we, go;
  logic [ADDR_W-1:0]  h_addr;
  logic [DATA_W-1:0]  h_wdata, rd_data;

  assign is_cpu = (chain_q == CH_CPU_DBG);
  assign is_reg = (chain_q == CH_REGS);
  assign is_trc = (chain_q == CH_TRACE);

  assign payload_len = ir_chain_sel ? CNT_W'(FRM_SEL - CRC_W) :
                       is_cpu       ? CNT_W'(FRM_CPU - CRC_W) : CNT_W'(FRM_REG - CRC_W);
  assign frame_len   = payload_len + CNT_W'(CRC_W);

  dbgc_crc8_ser u_crc (
    .clk (tck), .rst (tck_rst), .init (capture_dr),
    .en  (shift_dr && (bit_cnt < payload_len)), .din (tdi), .crc (crc_calc)
  );

  always_comb begin
    trace_crc = CRC_SEED;
    for (int i = 0; i < TRACE_W; i++) trace_crc = crc8_step(trace_crc, trace_sample[i]);
  end

  assign frame_ok = (sr[OFF_CRC +: CRC_W] == crc_calc) && (bit_cnt == frame_len);
  assign sel_upd  = update_dr && ir_chain_sel;
  assign cmd_upd  = update_dr && ir_debug && !ir_chain_sel && (is_cpu || is_reg);
  assign tdo      = sr[0];

  always_ff @(posedge tck) begin
    if (tck_rst) begin
      sr <= '0; bit_cnt <= '0;
    end else if (capture_dr) begin
      bit_cnt <= '0;
      if (ir_debug && is_trc)                 sr <= SR_W'({trace_crc, trace_sample});
      else if (ir_debug && (is_cpu || is_reg)) sr <= SR_W'(rd_data);
      else                                     sr <= '0;
    end else if (shift_dr) begin
      sr <= {tdi, sr[SR_W-1:1]};
      if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge tck) begin
    if (tck_rst) begin
      chain_q <= CH_BSCAN; crc_error <= 1'b0; req_tgl <= 1'b0;
      h_cpu <= 1'b0; h_we <= 1'b0; h_addr <= '0; h_wdata <= '0;
    end else if (sel_upd) begin
      if (frame_ok) begin
        chain_q   <= sr[OFF_CHAIN +: CHAIN_W];
        crc_error <= 1'b0;
      end else begin
        crc_error <= 1'b1;
      end
    end else if (cmd_upd) begin
      if (frame_ok) begin
        h_cpu   <= is_cpu;
        h_we    <= sr[OFF_WE];
        h_wdata <= sr[OFF_DATA +: DATA_W];
        h_addr  <= is_cpu ? sr[OFF_CADDR +: ADDR_W] : ADDR_W'(sr[OFF_RADDR +: REG_AW]);
        req_tgl <= ~req_tgl;
      end else begin
        crc_error <= 1'b1;
      end
    end
  end

  dbgc_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (sys_clk), .rst (sys_rst), .tgl_in (req_tgl), .pulse (go)
  );

  dbgc_sys_port #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .REG_AW (REG_AW), .REG_COUNT (REG_COUNT)
  ) u_port (
    .clk (sys_clk), .rst (sys_rst), .go (go),
    .h_cpu (h_cpu), .h_we (h_we), .h_addr (h_addr), .h_wdata (h_wdata),
    .cpu_rdata (cpu_rdata), .reg_rdata (reg_rdata),
    .cpu_cs (cpu_cs), .cpu_we (cpu_we), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
    .reg_stb (reg_stb), .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .rd_data (rd_data)
  );

  // R1
  chain_upd_chk: assert property (@(posedge tck) disable iff (tck_rst)
    !$stable(chain_q) |-> $past(update_dr && ir_chain_sel));
  // R2
  err_set_chk: assert property (@(posedge tck) disable iff (tck_rst)
    $rose(crc_error) |-> $past(update_dr));
  // R2
  err_clr_chk: assert property (@(posedge tck) disable iff (tck_rst)
    $fell(crc_error) |-> $past(update_dr && ir_chain_sel));
  // R8
  req_len_chk: assert property (@(posedge tck) disable iff (tck_rst)
    (req_tgl != $past(req_tgl)) |-> $past(update_dr && ir_debug && (bit_cnt == frame_len)));
endmodule

// File: tb/sim_dbgc_jtag_cmd.sv
`timescale 1ns/1ps
module sim_dbgc_jtag_cmd;
  localparam logic [3:0] ID_BSCAN = 4'd0, ID_CPU = 4'd1, ID_CTST = 4'd2, ID_TRC = 4'd3, ID_REGS = 4'd4;
  localparam logic [31:0] RD_KEY = 32'h5A5A_C3C3;

  logic tck = 1'b0, sys_clk = 1'b0;
  logic tck_rst, sys_rst, capture_dr, shift_dr, update_dr, ir_chain_sel, ir_debug, tdi;
  logic tdo, crc_error, cpu_cs, cpu_we, reg_stb, reg_we;
  logic [39:0] trace_sample;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata, reg_wdata, reg_rdata;
  logic [4:0]  reg_addr;

  always #4 sys_clk = ~sys_clk;
  initial begin #3; forever #40 tck = ~tck; end

  dbgc_jtag_cmd u0 (
    .tck(tck), .tck_rst(tck_rst), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .ir_chain_sel(ir_chain_sel), .ir_debug(ir_debug), .tdi(tdi),
    .tdo(tdo), .crc_error(crc_error), .trace_sample(trace_sample),
    .sys_clk(sys_clk), .sys_rst(sys_rst), .cpu_cs(cpu_cs), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .reg_stb(reg_stb), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // environment: register file slave and processor slave
  logic [31:0] bregs [16];
  initial for (int i = 0; i < 16; i++) bregs[i] = '0;
  always @(posedge sys_clk) if (reg_stb && reg_we) bregs[reg_addr[3:0]] <= reg_wdata;
  assign reg_rdata = bregs[reg_addr[3:0]];
  assign cpu_rdata = cpu_addr ^ RD_KEY;

  int n_cpu = 0, n_reg = 0, n_long = 0, n_both = 0;
  logic prev_cs = 1'b0, prev_rs = 1'b0;
  always @(posedge sys_clk) begin
    if (cpu_cs) n_cpu++;
    if (reg_stb) n_reg++;
    if ((cpu_cs && prev_cs) || (reg_stb && prev_rs)) n_long++;
    if (cpu_cs && reg_stb) n_both++;
    prev_cs <= cpu_cs;
    prev_rs <= reg_stb;
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bcrc(input logic [127:0] b, input int n);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n; i++) begin
      logic f = c[7] ^ b[i];
      c = {c[6:0], 1'b0} ^ (f ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [127:0] sel_frm(input logic [3:0] id, input logic [7:0] flip);
    logic [127:0] f = '0;
    f[3:0] = id;
    f[11:4] = bcrc(f, 4) ^ flip;
    return f;
  endfunction

  function automatic logic [127:0] reg_frm(input logic [4:0] a, input logic we, input logic [31:0] d,
                                           input logic [7:0] flip);
    logic [127:0] f = '0;
    f[4:0] = a; f[5] = we; f[37:6] = d;
    f[45:38] = bcrc(f, 38) ^ flip;
    return f;
  endfunction

  function automatic logic [127:0] cpu_frm(input logic [31:0] a, input logic we, input logic [31:0] d,
                                           input logic [7:0] flip);
    logic [127:0] f = '0;
    f[31:0] = a; f[32] = we; f[64:33] = d;
    f[72:65] = bcrc(f, 65) ^ flip;
    return f;
  endfunction

  logic [127:0] tout;
  task automatic scan(input logic [127:0] din, input int len, input logic sel);
    tout = '0;
    @(negedge tck); ir_chain_sel = sel; ir_debug = !sel; capture_dr = 1'b1;
    @(negedge tck); capture_dr = 1'b0; shift_dr = 1'b1;
    for (int i = 0; i < len; i++) begin
      tdi = din[i]; tout[i] = tdo;
      @(negedge tck);
    end
    shift_dr = 1'b0; update_dr = 1'b1; tdi = 1'b0;
    @(negedge tck); update_dr = 1'b0;
    repeat (10) @(negedge tck);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  logic [31:0] exp_regs [16];
  initial begin
    int c0, r0, prev;
    logic [4:0] a;
    logic [31:0] d, ca, last_rd;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) exp_regs[i] = '0;
    tck_rst = 1; sys_rst = 1; capture_dr = 0; shift_dr = 0; update_dr = 0;
    ir_chain_sel = 0; ir_debug = 0; tdi = 0; trace_sample = '0;
    repeat (4) @(negedge tck);
    tck_rst = 0; sys_rst = 0;
    repeat (2) @(negedge tck);
    chk("R1 reset tdo", tdo, 0);
    chk("R2 reset crc_error", crc_error, 0);

    // R11: chain 0 after reset, command frames ignored
    r0 = n_reg;
    scan(reg_frm(5'd1, 1'b1, 32'hDEAD_0001, 8'h00), 46, 1'b0);
    chk("R11 no access on chain 0", n_reg, r0);
    chk("R11 no error on chain 0", crc_error, 0);

    scan(sel_frm(ID_REGS, 8'h00), 12, 1'b1);
    chk("R1 select register chain", crc_error, 0);

    // R3 R5 random writes
    for (int k = 0; k < 12; k++) begin
      a = 5'($urandom % 16); d = $urandom;
      r0 = n_reg;
      scan(reg_frm(a, 1'b1, d, 8'h00), 46, 1'b0);
      exp_regs[a[3:0]] = d;
      chk("R10 one write strobe", n_reg, r0 + 1);
      chk("R3 write addr/data/we", {reg_we, reg_addr, reg_wdata}, {1'b1, a, d});
    end

    // R6 random reads, result on next scan
    prev = -1;
    for (int k = 0; k < 8; k++) begin
      a = 5'($urandom % 16);
      r0 = n_reg;
      scan(reg_frm(a, 1'b0, $urandom, 8'h00), 46, 1'b0);
      chk("R5 read strobe", {n_reg, 31'(reg_we)}, {r0 + 1, 31'd0});
      if (prev >= 0) chk("R6 readback", tout[31:0], exp_regs[prev]);
      prev = int'(a[3:0]);
    end

    // R7 unmapped read
    r0 = n_reg;
    scan(reg_frm(5'd23, 1'b0, 32'h1234_5678, 8'h00), 46, 1'b0);
    chk("R6 readback before unmapped", tout[31:0], exp_regs[prev]);
    chk("R7 no strobe unmapped", n_reg, r0);
    chk("R7 no error unmapped", crc_error, 0);
    scan(reg_frm(5'd31, 1'b0, 32'h0, 8'h00), 46, 1'b0);
    chk("R7 unmapped returns zero", tout[31:0], 32'h0);

    // R2 bad CRC write discarded
    r0 = n_reg;
    scan(reg_frm(5'd3, 1'b1, 32'hBAD0_BAD0, 8'h01), 46, 1'b0);
    chk("R2 no strobe bad crc", n_reg, r0);
    chk("R2 error set", crc_error, 1);
    scan(reg_frm(5'd3, 1'b0, 32'h0, 8'h00), 46, 1'b0);
    scan(reg_frm(5'd3, 1'b0, 32'h0, 8'h00), 46, 1'b0);
    chk("R2 register unchanged", tout[31:0], exp_regs[3]);
    scan(sel_frm(ID_REGS, 8'h00), 12, 1'b1);
    chk("R2 error cleared by select", crc_error, 0);

    // R8 short frame
    r0 = n_reg;
    scan(reg_frm(5'd5, 1'b1, 32'h5555_AAAA, 8'h00), 45, 1'b0);
    chk("R8 short frame no strobe", n_reg, r0);
    chk("R8 short frame error", crc_error, 1);

    // R1 bad select keeps chain
    scan(sel_frm(ID_CPU, 8'h80), 12, 1'b1);
    chk("R1 bad select error", crc_error, 1);
    r0 = n_reg; c0 = n_cpu;
    scan(reg_frm(5'd6, 1'b1, 32'h6666_0006, 8'h00), 46, 1'b0);
    exp_regs[6] = 32'h6666_0006;
    chk("R1 chain kept after bad select", {n_reg, n_cpu}, {r0 + 1, c0});

    scan(sel_frm(ID_CPU, 8'h00), 12, 1'b1);
    chk("R1 select cpu chain", crc_error, 0);

    // R4 processor writes
    for (int k = 0; k < 6; k++) begin
      ca = $urandom; d = $urandom;
      c0 = n_cpu;
      scan(cpu_frm(ca, 1'b1, d, 8'h00), 73, 1'b0);
      chk("R4 one cpu strobe", n_cpu, c0 + 1);
      chk("R4 cpu addr/data/we", {cpu_we, cpu_addr, cpu_wdata}, {1'b1, ca, d});
    end

    // R6 processor read, write keeps held value
    ca = $urandom;
    scan(cpu_frm(ca, 1'b0, $urandom, 8'h00), 73, 1'b0);
    chk("R4 cpu read we", cpu_we, 0);
    last_rd = ca ^ RD_KEY;
    scan(cpu_frm($urandom, 1'b1, $urandom, 8'h00), 73, 1'b0);
    chk("R6 cpu readback", tout[31:0], last_rd);
    scan(cpu_frm(32'h0, 1'b1, 32'h0, 8'h00), 73, 1'b0);
    chk("R6 write leaves read data", tout[31:0], last_rd);

    chk("R10 strobes single cycle", n_long, 0);
    chk("R10 strobes exclusive", n_both, 0);

    // R9 trace chain
    scan(sel_frm(ID_TRC, 8'h00), 12, 1'b1);
    for (int k = 0; k < 3; k++) begin
      logic [127:0] tv = '0;
      tv[39:0] = {8'($urandom), $urandom};
      trace_sample = tv[39:0];
      scan('0, 48, 1'b0);
      chk("R9 trace sample", tout[39:0], tv[39:0]);
      chk("R9 trace crc", tout[47:40], bcrc(tv, 40));
    end

    // R11 chain 2
    scan(sel_frm(ID_CTST, 8'h00), 12, 1'b1);
    r0 = n_reg; c0 = n_cpu;
    scan(cpu_frm(32'h77, 1'b1, 32'h77, 8'h00), 73, 1'b0);
    scan(cpu_frm(32'h78, 1'b1, 32'h78, 8'h3C), 73, 1'b0);
    chk("R11 no access on chain 2", {n_reg, n_cpu}, {r0, c0});
    chk("R11 no error on chain 2", crc_error, 0);

    finish_run();
  end
endmodule